// File: doc/BRIEF.md
# Banked Memory Mapper with Chip-Select Decoding

This block sits between a 6502-family CPU and its memories in a small playback system. It decodes the 16-bit CPU address into chip enables for three RAM regions, a small peripheral register window and a flash device. Every enable is qualified by the phi2 clock. The upper 32KB of the CPU space is split into eight 4KB windows. Each window has a write-only page register, and a chunk register selects which 64KB slice of flash the pages come from. Together they form the extended flash address.

A playback program may remap any window at any time, including the topmost one that holds the interrupt vectors. The mapper therefore holds a 16-bit NMI vector override. When it is enabled, the mapper answers CPU reads of the NMI vector bytes itself and keeps the flash off the bus. A free-running divider drives the CPU's active-low NMI pin with one pulse per period (50 Hz in the intended system). The pulse is held low for a set number of CPU cycles.

All outputs are registered on the system clock `clk`, one cycle after the inputs they depend on. Register writes take effect on the `clk` edges that fall inside a phi2-high write cycle.

Top module: `bank_mapper`

## Requirements
- R1: `ram_ce` is high for $0000-$1FFF, $3000-$3FFF and $6000-$7FFF, and at most one of `ram_ce`, `per_ce` and `flash_ce` is high at a time.
- R2: `per_ce` is high for $2000-$2007. The internal registers sit at $2004 (chunk), $2005 (override low byte), $2006 (override high byte) and $2007 (control, bit 0 = override enable). All four read back as full bytes.
- R3: A write to $5FF8+n loads the page register for window n, which covers $8000+n*$1000 to $8FFF+n*$1000. Reads of $5FF8-$5FFF drive nothing, and no chip enable is raised for that range.
- R4: `flash_ce` is high for $8000-$FFFF. `flash_addr` = {chunk[CHUNK_W-1:0], page[n][PAGE_W-1:0], addr[11:0]}.
- R5: A write to $2004 stores all 8 bits. Only the low CHUNK_W bits take part in `flash_addr`.
- R6: After reset the chunk is 0, page register n holds n (identity map), the override is disabled, every enable and `cpu_doe` is low, and `nmi_n` is high.
- R7: While the override is enabled, any access to $FFFA or $FFFB keeps `flash_ce` low. A read of either address drives the low or high override byte on `cpu_dout` with `cpu_doe` high. While the override is disabled, those addresses map to flash like any other.
- R8: While phi2 is low, no enable and no `cpu_doe` is raised, and writes have no effect.
- R9: `cpu_doe` is raised only for reads (R/W high) of the internal registers or of the overridden vector.
- R10: `nmi_n` falls once every TICK_DIV clock cycles. It then stays low for NMI_HOLD rising edges of phi2.
- R11: Addresses outside all decoded ranges (such as $2008, $2FFF, $4000 and $5FF7) raise no enable.
- R12: Each output reflects the inputs sampled at the previous `clk` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | CPU phase-2 clock, qualifies all accesses |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_din | input | 8 | CPU write data |
| cpu_dout | output | 8 | Read data for internal registers and vector override |
| cpu_doe | output | 1 | Drive enable for cpu_dout |
| ram_ce | output | 1 | RAM chip enable |
| per_ce | output | 1 | Peripheral window enable |
| flash_ce | output | 1 | Flash chip enable |
| flash_addr | output | CHUNK_W+PAGE_W+12 | Extended flash address |
| nmi_n | output | 1 | Active-low periodic NMI |

## Verification
The hardest case to reach is a vector fetch after the top window has been remapped while the override is active. The flash must stay dark and the bus must carry the programmed bytes. To get there, the stimulus table remaps window 7, changes the chunk, loads both override bytes, enables the override, and then reads $FFFA, $FFFB and the neighbouring $FFFC. A reset then checks that the identity map and the disabled override are restored. The NMI pulse is measured separately while phi2 toggles, so that its low time can be counted in phi2 edges.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_RAM,
    RGN_PER,
    RGN_BANKREG,
    RGN_FLASH
  } region_e;

  localparam logic [15:0] CHUNK_ADDR = 16'h2004;
  localparam logic [15:0] VLO_ADDR   = 16'h2005;
  localparam logic [15:0] VHI_ADDR   = 16'h2006;
  localparam logic [15:0] CTRL_ADDR  = 16'h2007;
  localparam logic [14:0] NMI_VEC_HI15 = 15'h7FFD; // $FFFA/$FFFB >> 1

endpackage

// File: rtl/mapper_addr_decode.sv
module mapper_addr_decode
  import bank_mapper_pkg::*;
(
  input  logic [15:0] addr,
  output region_e     region
);

  always_comb begin
    region = RGN_NONE;
    if (addr[15])
      region = RGN_FLASH;
    else if (addr[15:13] == 3'b000 || addr[15:12] == 4'h3 || addr[15:13] == 3'b011)
      region = RGN_RAM;
    else if (addr[15:3] == 13'h0400)
      region = RGN_PER;
    else if (addr[15:3] == 13'h0BFF)
      region = RGN_BANKREG;
  end

endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
  import bank_mapper_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int NWIN   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  region_e           region,
  input  logic [15:0]       addr,
  input  logic [7:0]        din,
  input  logic [$clog2(NWIN)-1:0] win_sel,
  output logic [PAGE_W-1:0] page,
  output logic [7:0]        chunk_q,
  output logic [7:0]        vlo_q,
  output logic [7:0]        vhi_q,
  output logic [7:0]        ctrl_q
);

  localparam int IDX_W = $clog2(NWIN);

  logic [PAGE_W-1:0] page_q [NWIN];

  for (genvar n = 0; n < NWIN; n++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)
        page_q[n] <= PAGE_W'(n);
      else if (wr_stb && region == RGN_BANKREG && addr[IDX_W-1:0] == IDX_W'(n))
        page_q[n] <= din[PAGE_W-1:0];
    end
  end

  assign page = page_q[win_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      chunk_q <= '0;
      vlo_q   <= '0;
      vhi_q   <= '0;
      ctrl_q  <= '0;
    end else if (wr_stb) begin
      if (addr == CHUNK_ADDR) chunk_q <= din;
      if (addr == VLO_ADDR)   vlo_q   <= din;
      if (addr == VHI_ADDR)   vhi_q   <= din;
      if (addr == CTRL_ADDR)  ctrl_q  <= din;
    end
  end

endmodule

// File: rtl/mapper_nmi_tick.sv
module mapper_nmi_tick #(
  parameter int TICK_DIV = 1000000,
  parameter int NMI_HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  output logic nmi_n
);

  localparam int CNT_W  = $clog2(TICK_DIV);
  localparam int HOLD_W = $clog2(NMI_HOLD + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              p2_q, tick, p2_rise;

  assign tick    = (cnt_q == CNT_W'(TICK_DIV - 1));
  assign p2_rise = phi2 & ~p2_q;

  always_comb begin
    hold_d = hold_q;
    if (tick)
      hold_d = HOLD_W'(NMI_HOLD);
    else if (p2_rise && hold_q != '0)
      hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      p2_q   <= 1'b0;
      nmi_n  <= 1'b1;
    end else begin
      cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      hold_q <= hold_d;
      p2_q   <= phi2;
      nmi_n  <= (hold_d == '0);
    end
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int CHUNK_W  = 4,
  parameter int PAGE_W   = 4,
  parameter int TICK_DIV = 1000000,
  parameter int NMI_HOLD = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        phi2,
  input  logic [15:0]                 cpu_addr,
  input  logic                        cpu_rw,
  input  logic [7:0]                  cpu_din,
  output logic [7:0]                  cpu_dout,
  output logic                        cpu_doe,
  output logic                        ram_ce,
  output logic                        per_ce,
  output logic                        flash_ce,
  output logic [CHUNK_W+PAGE_W+11:0]  flash_addr,
  output logic                        nmi_n
);

  localparam int NWIN = 8;
  localparam int FA_W = CHUNK_W + PAGE_W + 12;

  region_e           rgn;
  logic [PAGE_W-1:0] page;
  logic [7:0]        chunk_q, vlo_q, vhi_q, ctrl_q;
  logic              wr_stb, rd_acc, vec_hit, reg_hit;
  logic [7:0]        dout_d;
  logic              doe_d;

  mapper_addr_decode u_dec (
    .addr   (cpu_addr),
    .region (rgn)
  );

  assign wr_stb = phi2 & ~cpu_rw;
  assign rd_acc = phi2 &  cpu_rw;

  mapper_bank_regs #(.PAGE_W(PAGE_W), .NWIN(NWIN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .region  (rgn),
    .addr    (cpu_addr),
    .din     (cpu_din),
    .win_sel (cpu_addr[14:12]),
    .page    (page),
    .chunk_q (chunk_q),
    .vlo_q   (vlo_q),
    .vhi_q   (vhi_q),
    .ctrl_q  (ctrl_q)
  );

  mapper_nmi_tick #(.TICK_DIV(TICK_DIV), .NMI_HOLD(NMI_HOLD)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .phi2  (phi2),
    .nmi_n (nmi_n)
  );

  assign vec_hit = ctrl_q[0] && (cpu_addr[15:1] == NMI_VEC_HI15);
  assign reg_hit = (rgn == RGN_PER) && cpu_addr[2];

  always_comb begin
    dout_d = 8'h00;
    doe_d  = 1'b0;
    if (rd_acc && vec_hit) begin
      doe_d  = 1'b1;
      dout_d = cpu_addr[0] ? vhi_q : vlo_q;
    end else if (rd_acc && reg_hit) begin
      doe_d = 1'b1;
      case (cpu_addr[1:0])
        2'd0:    dout_d = chunk_q;
        2'd1:    dout_d = vlo_q;
        2'd2:    dout_d = vhi_q;
        default: dout_d = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_dout   <= '0;
      cpu_doe    <= 1'b0;
      ram_ce     <= 1'b0;
      per_ce     <= 1'b0;
      flash_ce   <= 1'b0;
      flash_addr <= '0;
    end else begin
      cpu_dout   <= dout_d;
      cpu_doe    <= doe_d;
      ram_ce     <= phi2 && rgn == RGN_RAM;
      per_ce     <= phi2 && rgn == RGN_PER;
      flash_ce   <= phi2 && rgn == RGN_FLASH && !vec_hit;
      flash_addr <= FA_W'({chunk_q[CHUNK_W-1:0], page, cpu_addr[11:0]});
    end
  end

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
  input logic clk,
  input logic rst,
  input logic phi2,
  input logic cpu_rw,
  input logic cpu_doe,
  input logic ram_ce,
  input logic per_ce,
  input logic flash_ce,
  input logic nmi_n
);

  // R1
  one_region_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_ce, per_ce, flash_ce}));

  // R8
  phi2_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(phi2) |-> !(ram_ce || per_ce || flash_ce || cpu_doe));

  // R9
  read_only_drive_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_doe |-> ($past(cpu_rw) && $past(phi2)));

  // R7
  vec_no_flash_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpu_doe && flash_ce));

  // R10
  nmi_min_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |=> !nmi_n);

endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .phi2     (phi2),
  .cpu_rw   (cpu_rw),
  .cpu_doe  (cpu_doe),
  .ram_ce   (ram_ce),
  .per_ce   (per_ce),
  .flash_ce (flash_ce),
  .nmi_n    (nmi_n)
);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

  localparam int CW = 4;
  localparam int PW = 4;
  localparam int FA = CW + PW + 12;
  localparam int DIV = 40;
  localparam int HOLD = 3;
  localparam int VW = 2 + 16 + 8 + 4 + 8 + FA;
  localparam int NV = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          phi2 = 1'b1;
  logic [15:0]   cpu_addr = '0;
  logic          cpu_rw = 1'b1;
  logic [7:0]    cpu_din = '0;
  logic [7:0]    cpu_dout;
  logic          cpu_doe, ram_ce, per_ce, flash_ce, nmi_n;
  logic [FA-1:0] flash_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bank_mapper #(.CHUNK_W(CW), .PAGE_W(PW), .TICK_DIV(DIV), .NMI_HOLD(HOLD)) u_bank_mapper (
    .clk(clk), .rst(rst), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .ram_ce(ram_ce),
    .per_ce(per_ce), .flash_ce(flash_ce), .flash_addr(flash_addr), .nmi_n(nmi_n)
  );

  function automatic logic [VW-1:0] mk(input logic p, input logic rw, input logic [15:0] a,
                                        input logic [7:0] d, input logic r, input logic pe,
                                        input logic f, input logic oe, input logic [7:0] q,
                                        input logic [FA-1:0] fa);
    return {p, rw, a, d, r, pe, f, oe, q, fa};
  endfunction

  // phi2, rw, addr, din | ram, per, flash, doe, dout, flash_addr
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(1,1,16'h0000,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h1FFF,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h2000,8'h00, 0,1,0,0,8'h00,20'h0),      // R2
    mk(1,1,16'h2007,8'h00, 0,1,0,1,8'h00,20'h0),      // R2 R6 override off
    mk(1,1,16'h2008,8'h00, 0,0,0,0,8'h00,20'h0),      // R11
    mk(1,1,16'h3000,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h2FFF,8'h00, 0,0,0,0,8'h00,20'h0),      // R11
    mk(1,1,16'h3FFF,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h4000,8'h00, 0,0,0,0,8'h00,20'h0),      // R11
    mk(1,1,16'h5FF7,8'h00, 0,0,0,0,8'h00,20'h0),      // R11
    mk(1,1,16'h6000,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h7FFF,8'h00, 1,0,0,0,8'h00,20'h0),      // R1
    mk(1,1,16'h5FFF,8'h00, 0,0,0,0,8'h00,20'h0),      // R3
    mk(1,1,16'h8123,8'h00, 0,0,1,0,8'h00,20'h00123),  // R4 R6 identity
    mk(1,1,16'hF456,8'h00, 0,0,1,0,8'h00,20'h07456),  // R4 R6
    mk(1,0,16'h5FFF,8'h0A, 0,0,0,0,8'h00,20'h0),      // R3 write window 7
    mk(1,1,16'hF456,8'h00, 0,0,1,0,8'h00,20'h0A456),  // R3
    mk(1,1,16'h5FFF,8'h00, 0,0,0,0,8'h00,20'h0),      // R3 write-only
    mk(1,0,16'h2004,8'h03, 0,1,0,0,8'h00,20'h0),      // R5
    mk(1,1,16'h2004,8'h00, 0,1,0,1,8'h03,20'h0),      // R5
    mk(1,1,16'h9ABC,8'h00, 0,0,1,0,8'h00,20'h31ABC),  // R4 R5
    mk(1,1,16'hFFFA,8'h00, 0,0,1,0,8'h00,20'h3AFFA),  // R7 disabled
    mk(1,0,16'h2005,8'h34, 0,1,0,0,8'h00,20'h0),      // R7
    mk(1,0,16'h2006,8'h12, 0,1,0,0,8'h00,20'h0),      // R7
    mk(1,0,16'h2007,8'h01, 0,1,0,0,8'h00,20'h0),      // R7
    mk(1,1,16'hFFFA,8'h00, 0,0,0,1,8'h34,20'h0),      // R7
    mk(1,1,16'hFFFB,8'h00, 0,0,0,1,8'h12,20'h0),      // R7
    mk(1,1,16'hFFFC,8'h00, 0,0,1,0,8'h00,20'h3AFFC),  // R7 neighbour
    mk(0,1,16'h0000,8'h00, 0,0,0,0,8'h00,20'h0),      // R8
    mk(0,0,16'h5FF8,8'h05, 0,0,0,0,8'h00,20'h0),      // R8 ignored write
    mk(1,1,16'h8000,8'h00, 0,0,1,0,8'h00,20'h30000),  // R8 page 0 kept
    mk(1,0,16'hFFFA,8'h00, 0,0,0,0,8'h00,20'h0),      // R9 write to vector
    mk(1,0,16'h2004,8'hF5, 0,1,0,0,8'h00,20'h0),      // R5
    mk(1,1,16'h2004,8'h00, 0,1,0,1,8'hF5,20'h0)       // R5 full byte
  };

  task automatic drive(input logic p, input logic rw, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    phi2 = p; cpu_rw = rw; cpu_addr = a; cpu_din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_access(input string req, input logic [15:0] a, input logic [FA-1:0] fa, input logic fl);
    drive(1, 1, a, 8'h00);
    check(req, {ram_ce, per_ce, flash_ce, cpu_doe, fl ? flash_addr : '0},
               {1'b0, 1'b0, fl, 1'b0, fl ? fa : '0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    check("R6", {ram_ce, per_ce, flash_ce, cpu_doe, nmi_n}, 5'b00001);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      logic [FA+11:0] act, exp;
      v = VEC[i];
      drive(v[VW-1], v[VW-2], v[VW-3 -: 16], v[VW-19 -: 8]);
      exp = {v[FA+11 -: 4], v[FA+8] ? v[FA+7 -: 8] : 8'h00, v[FA+9] ? v[FA-1:0] : '0};
      act = {ram_ce, per_ce, flash_ce, cpu_doe, cpu_doe ? cpu_dout : 8'h00,
             v[FA+9] ? flash_addr : '0};
      check($sformatf("R12 vector %0d", i), 64'(act), 64'(exp));
    end

    // R6: reset restores identity map, chunk 0, override off
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_access("R6 identity", 16'hF456, 20'h07456, 1'b1);
    check_access("R6 vector", 16'hFFFA, 20'h07FFA, 1'b1);
    drive(1, 1, 16'h2004, 8'h00);
    check("R6 chunk", {cpu_doe, cpu_dout}, 9'h100);

    // R3: each window independently remapped
    for (int w = 0; w < 8; w++) drive(1, 0, 16'h5FF8 + 16'(w), 8'(15 - w));
    for (int w = 0; w < 8; w++)
      check_access("R3 window", 16'h8000 + 16'(w) * 16'h1000 + 16'h0ABC,
                   {4'h0, 4'(15 - w), 12'hABC}, 1'b1);

    // R10: NMI period and low time
    @(negedge clk);
    rst = 1'b1;
    phi2 = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 idle", {31'd0, nmi_n}, 1);
    begin
      int fall0 = -1, fall1 = -1, rise0 = -1;
      logic prev = 1'b1;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        phi2 = ~phi2;
        #1;
        if (prev && !nmi_n) begin
          if (fall0 < 0) fall0 = c; else if (fall1 < 0) fall1 = c;
        end
        if (!prev && nmi_n && fall0 >= 0 && rise0 < 0) rise0 = c;
        prev = nmi_n;
      end
      check("R10 period", 64'(fall1 - fall0), 64'(DIV));
      check("R10 low", 64'((rise0 - fall0 >= 2*HOLD-1) && (rise0 - fall0 <= 2*HOLD+1)), 64'(1));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule